// File: doc/BRIEF.md
# Buffered Data-Set Output Port

This block sits at the end of a receive processing chain. It hands finished results to a host processor in two ways. Each processed result is a data set of five fields: in-phase (I), quadrature (Q), magnitude, phase and frequency. Data sets are written into a small first-in first-out store. The host reads the oldest stored set one field at a time by placing a 3-bit field code on `fieldSel`. It moves on to the next set by pulsing `popStb`. When a set lands in an empty store, an active-low interrupt is held low for a fixed number of cycles to tell the host that data is waiting.

Alongside the store, a direct path registers a pair of words whenever `dirValid` is high. The high byte of each word is shown on the upper byte lane of its bus, and a one-cycle active-low ready strobe marks the first cycle of new data. The selected field of the buffered set is split across the lower byte lanes of the two buses: its high byte goes on bus A and its low byte on bus B. This lets buffered reads and direct output run at the same time. Each of the four byte lanes has its own active-low enable, and a lane that is not enabled reads as zero.

Top module: `dset_out_port`

## Requirements
- R1: With a set stored, field codes 0, 1, 2, 3 and 4 select I, Q, magnitude, phase and frequency of the oldest set. The selected 16-bit word appears as `busA[7:0]` = word[15:8] and `busB[7:0]` = word[7:0] in the same cycle (combinational select, `fieldSel[2]` is the MSB).
- R2: Field codes 5, 6 and 7 drive zero on both low byte lanes.
- R3: The store holds up to DEPTH (default 7) sets. A set offered while the store is full and no pop is taken in the same cycle is discarded. It then sets `ovfl` high on the next cycle, and `ovfl` stays high until reset.
- R4: Sets are read back in arrival order. A `popStb` cycle with a non-empty store removes the oldest set at the next clock edge.
- R5: When the store is empty the low byte lanes read zero, and a `popStb` is ignored: a set written afterwards is read back intact as the oldest set.
- R6: Writing a set into an empty store while `irqN` is high drives `irqN` low from the next cycle for exactly IRQ_LEN (default 8) cycles. A new write into an empty store while `irqN` is already low does not lengthen the pulse.
- R7: A cycle with `dirValid` high registers `dirA` and `dirB`. From the next cycle `busA[15:8]` and `busB[15:8]` show their high bytes until the next load, and `dataRdyN` is low for exactly that first cycle.
- R8: Each of `oeAHiN`, `oeALoN`, `oeBHiN`, `oeBLoN`, when high, forces its byte lane (A high, A low, B high, B low) to zero without affecting the other lanes.
- R9: When the store is full and `setValid` and `popStb` are high in the same cycle, the oldest set leaves and the new set is accepted at the tail.
- R10: After reset both buses read zero, `irqN` and `dataRdyN` are high, and `ovfl` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| setValid | input | 1 | Offers a new data set this cycle |
| iIn | input | 16 | I field of the offered set |
| qIn | input | 16 | Q field of the offered set |
| magIn | input | 16 | Magnitude field of the offered set |
| phsIn | input | 16 | Phase field of the offered set |
| frqIn | input | 16 | Frequency field of the offered set |
| popStb | input | 1 | Removes the oldest stored set |
| fieldSel | input | 3 | Field code for the buffered read |
| dirValid | input | 1 | Loads new direct-output words |
| dirA | input | 16 | Direct word for bus A |
| dirB | input | 16 | Direct word for bus B |
| oeAHiN | input | 1 | Enable for bus A high byte, active low |
| oeALoN | input | 1 | Enable for bus A low byte, active low |
| oeBHiN | input | 1 | Enable for bus B high byte, active low |
| oeBLoN | input | 1 | Enable for bus B low byte, active low |
| busA | output | 16 | Direct high byte A and buffered word high byte |
| busB | output | 16 | Direct high byte B and buffered word low byte |
| irqN | output | 1 | Buffered-data interrupt, active low |
| dataRdyN | output | 1 | Direct-data ready strobe, active low |
| ovfl | output | 1 | Sticky flag for a discarded set |

## Verification
The bench builds the block with its defaults: DEPTH of 7, IRQ_LEN of 8 and 16-bit fields. A depth of seven leaves the 3-bit read and write pointers one short of their natural range. Filling, overflowing and draining the store therefore forces the wrap from index 6 back to 0, which a power-of-two depth would never test. The overflow and the full-store push with pop are reached within a few dozen cycles. The eight-cycle interrupt is short enough to count cycle by cycle from both edges.

// File: rtl/dsout_pkg.sv
package dsout_pkg;

  localparam int NUM_FIELDS = 5;

  // field codes seen by the host on the select input
  typedef enum logic [2:0] {
    FLD_I   = 3'd0,
    FLD_Q   = 3'd1,
    FLD_MAG = 3'd2,
    FLD_PHS = 3'd3,
    FLD_FRQ = 3'd4
  } fieldCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;     // write offered set at the tail
    logic dirLoad;  // capture new direct words
  } ctlStb_t;

endpackage

// File: rtl/ds_ctrl.sv
module ds_ctrl
  import dsout_pkg::*;
#(
  parameter int DEPTH   = 7,
  parameter int IRQ_LEN = 8,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             setValid,
  input  logic             popStb,
  input  logic             dirValid,
  output ctlStb_t          stb,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic             headValid,
  output logic             irqN,
  output logic             dataRdyN,
  output logic             ovfl
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IRQ_W = $clog2(IRQ_LEN + 1);

  logic [CNT_W-1:0] setCount;
  logic [IRQ_W-1:0] irqCnt;
  logic             rdyPulse;
  logic             isEmpty;
  logic             isFull;
  logic             doPop;
  logic             doPush;
  logic             doDrop;
  logic             irqStart;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    isEmpty  = (setCount == '0);
    isFull   = (setCount == CNT_W'(DEPTH));
    doPop    = popStb && !isEmpty;
    doPush   = setValid && (!isFull || doPop);
    doDrop   = setValid && !doPush;
    irqStart = doPush && isEmpty && (irqCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setCount <= '0;
      wrIdx    <= '0;
      rdIdx    <= '0;
    end else begin
      setCount <= setCount + CNT_W'(doPush) - CNT_W'(doPop);
      if (doPush) wrIdx <= bumpPtr(wrIdx);
      if (doPop)  rdIdx <= bumpPtr(rdIdx);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfl <= 1'b0;
    end else if (doDrop) begin
      ovfl <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqCnt <= '0;
    end else if (irqStart) begin
      irqCnt <= IRQ_W'(IRQ_LEN);
    end else if (irqCnt != '0) begin
      irqCnt <= irqCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdyPulse <= 1'b0;
    else       rdyPulse <= dirValid;
  end

  assign stb.push    = doPush;
  assign stb.dirLoad = dirValid;
  assign headValid   = !isEmpty;
  assign irqN        = (irqCnt == '0);
  assign dataRdyN    = !rdyPulse;

endmodule

// File: rtl/ds_path.sv
module ds_path
  import dsout_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 7,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  ctlStb_t                             stb,
  input  logic [PTR_W-1:0]                    wrIdx,
  input  logic [PTR_W-1:0]                    rdIdx,
  input  logic                                headValid,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0]   setFields,
  input  logic [2:0]                          fieldSel,
  input  logic [DATA_W-1:0]                   dirA,
  input  logic [DATA_W-1:0]                   dirB,
  input  logic [3:0]                          laneOffN,
  output logic [DATA_W-1:0]                   busA,
  output logic [DATA_W-1:0]                   busB
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] setMem [DEPTH][NUM_FIELDS];
  logic [DATA_W-1:0] dirARegQ;
  logic [DATA_W-1:0] dirBRegQ;
  logic [DATA_W-1:0] selWord;
  logic [HALF-1:0]   laneSrc [4];
  logic [HALF-1:0]   laneOut [4];

  // one write port per field
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (stb.push) setMem[wrIdx][f] <= setFields[f];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirARegQ <= '0;
      dirBRegQ <= '0;
    end else if (stb.dirLoad) begin
      dirARegQ <= dirA;
      dirBRegQ <= dirB;
    end
  end

  always_comb begin
    selWord = '0;
    if (headValid && (fieldSel < 3'(NUM_FIELDS))) begin
      selWord = setMem[rdIdx][fieldSel];
    end
  end

  // lane order: 0 = A high, 1 = A low, 2 = B high, 3 = B low
  always_comb begin
    laneSrc[0] = dirARegQ[DATA_W-1:HALF];
    laneSrc[1] = selWord[DATA_W-1:HALF];
    laneSrc[2] = dirBRegQ[DATA_W-1:HALF];
    laneSrc[3] = selWord[HALF-1:0];
  end

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign laneOut[l] = laneOffN[l] ? '0 : laneSrc[l];
  end

  assign busA = {laneOut[0], laneOut[1]};
  assign busB = {laneOut[2], laneOut[3]};

endmodule

// File: rtl/dset_out_port.sv
module dset_out_port
  import dsout_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 7,
  parameter int IRQ_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setValid,
  input  logic [DATA_W-1:0] iIn,
  input  logic [DATA_W-1:0] qIn,
  input  logic [DATA_W-1:0] magIn,
  input  logic [DATA_W-1:0] phsIn,
  input  logic [DATA_W-1:0] frqIn,
  input  logic              popStb,
  input  logic [2:0]        fieldSel,
  input  logic              dirValid,
  input  logic [DATA_W-1:0] dirA,
  input  logic [DATA_W-1:0] dirB,
  input  logic              oeAHiN,
  input  logic              oeALoN,
  input  logic              oeBHiN,
  input  logic              oeBLoN,
  output logic [DATA_W-1:0] busA,
  output logic [DATA_W-1:0] busB,
  output logic              irqN,
  output logic              dataRdyN,
  output logic              ovfl
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ctlStb_t                           stb;
  logic [PTR_W-1:0]                  wrIdx;
  logic [PTR_W-1:0]                  rdIdx;
  logic                              headValid;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] setFields;

  always_comb begin
    setFields[FLD_I]   = iIn;
    setFields[FLD_Q]   = qIn;
    setFields[FLD_MAG] = magIn;
    setFields[FLD_PHS] = phsIn;
    setFields[FLD_FRQ] = frqIn;
  end

  ds_ctrl #(.DEPTH(DEPTH), .IRQ_LEN(IRQ_LEN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .setValid  (setValid),
    .popStb    (popStb),
    .dirValid  (dirValid),
    .stb       (stb),
    .wrIdx     (wrIdx),
    .rdIdx     (rdIdx),
    .headValid (headValid),
    .irqN      (irqN),
    .dataRdyN  (dataRdyN),
    .ovfl      (ovfl)
  );

  ds_path #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrIdx     (wrIdx),
    .rdIdx     (rdIdx),
    .headValid (headValid),
    .setFields (setFields),
    .fieldSel  (fieldSel),
    .dirA      (dirA),
    .dirB      (dirB),
    .laneOffN  ({oeBLoN, oeBHiN, oeALoN, oeAHiN}),
    .busA      (busA),
    .busB      (busB)
  );

endmodule

// File: rtl/dset_out_checker.sv
module dset_out_checker #(
  parameter int DATA_W  = 16,
  parameter int IRQ_LEN = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              setValid,
  input logic              dirValid,
  input logic [2:0]        fieldSel,
  input logic              oeAHiN,
  input logic              oeALoN,
  input logic              oeBHiN,
  input logic              oeBLoN,
  input logic [DATA_W-1:0] busA,
  input logic [DATA_W-1:0] busB,
  input logic              irqN,
  input logic              dataRdyN,
  input logic              ovfl
);

  localparam int HALF  = DATA_W / 2;
  localparam int RUN_W = $clog2(IRQ_LEN + 2) + 1;

  logic [RUN_W-1:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      lowRun <= '0;
    else if (!irqN) lowRun <= lowRun + 1'b1;
    else            lowRun <= '0;
  end

  p_irq_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqN) |-> (lowRun == RUN_W'(IRQ_LEN)));

  p_irq_max_r6: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (lowRun < RUN_W'(IRQ_LEN)));

  p_rdy_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dataRdyN |-> $past(dirValid));

  p_dir_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(dirValid) && !oeAHiN && !$past(oeAHiN)) |-> $stable(busA[DATA_W-1:HALF]));

  p_sel_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fieldSel > 3'd4) |-> (busA[HALF-1:0] == '0 && busB[HALF-1:0] == '0));

  p_lane_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (oeAHiN || oeALoN || oeBHiN || oeBLoN) |->
      ((!oeAHiN || busA[DATA_W-1:HALF] == '0) && (!oeALoN || busA[HALF-1:0] == '0) &&
       (!oeBHiN || busB[DATA_W-1:HALF] == '0) && (!oeBLoN || busB[HALF-1:0] == '0)));

  p_ovfl_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(ovfl) |-> ovfl);

  p_ovfl_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfl) |-> $past(setValid));

endmodule

bind dset_out_port dset_out_checker #(.DATA_W(DATA_W), .IRQ_LEN(IRQ_LEN)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .setValid (setValid),
  .dirValid (dirValid),
  .fieldSel (fieldSel),
  .oeAHiN   (oeAHiN),
  .oeALoN   (oeALoN),
  .oeBHiN   (oeBHiN),
  .oeBLoN   (oeBLoN),
  .busA     (busA),
  .busB     (busB),
  .irqN     (irqN),
  .dataRdyN (dataRdyN),
  .ovfl     (ovfl)
);

// File: tb/sim_dset_out_port.sv
`timescale 1ns/1ps
module sim_dset_out_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setValid = 1'b0;
  logic [15:0] iIn = '0, qIn = '0, magIn = '0, phsIn = '0, frqIn = '0;
  logic        popStb = 1'b0;
  logic [2:0]  fieldSel = 3'd0;
  logic        dirValid = 1'b0;
  logic [15:0] dirA = '0, dirB = '0;
  logic        oeAHiN = 1'b0, oeALoN = 1'b0, oeBHiN = 1'b0, oeBLoN = 1'b0;
  logic [15:0] busA, busB;
  logic        irqN, dataRdyN, ovfl;

  int nChk = 0;
  int nErr = 0;

  always #4 clk = ~clk;

  dset_out_port u0 (
    .clk(clk), .rstN(rstN), .setValid(setValid),
    .iIn(iIn), .qIn(qIn), .magIn(magIn), .phsIn(phsIn), .frqIn(frqIn),
    .popStb(popStb), .fieldSel(fieldSel), .dirValid(dirValid),
    .dirA(dirA), .dirB(dirB),
    .oeAHiN(oeAHiN), .oeALoN(oeALoN), .oeBHiN(oeBHiN), .oeBLoN(oeBLoN),
    .busA(busA), .busB(busB), .irqN(irqN), .dataRdyN(dataRdyN), .ovfl(ovfl)
  );

  // select code and expected word for a set with tag 0
  localparam logic [18:0] SEL_VEC [8] = '{
    {3'd0, 16'h0010}, {3'd1, 16'h0011}, {3'd2, 16'h0012}, {3'd3, 16'h0013},
    {3'd4, 16'h0014}, {3'd5, 16'h0000}, {3'd6, 16'h0000}, {3'd7, 16'h0000}
  };

  function automatic logic [15:0] fieldWord(input int tag, input int f);
    return {8'(tag), 8'(8'h10 + f)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // offer a set at a negedge; returns at the following negedge
  task automatic offerSet(input int tag, input logic withPop);
    iIn = fieldWord(tag, 0); qIn = fieldWord(tag, 1); magIn = fieldWord(tag, 2);
    phsIn = fieldWord(tag, 3); frqIn = fieldWord(tag, 4);
    setValid = 1'b1;
    popStb = withPop;
    @(negedge clk);
    setValid = 1'b0;
    popStb = 1'b0;
  endtask

  task automatic popOne();
    popStb = 1'b1;
    @(negedge clk);
    popStb = 1'b0;
  endtask

  function automatic logic [15:0] lowWord();
    return {busA[7:0], busB[7:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 busA", busA, 16'h0000);
    check("R10 busB", busB, 16'h0000);
    check("R10 flags", {irqN, dataRdyN, ovfl}, 3'b110);

    // R6 interrupt on first set into empty store
    offerSet(0, 1'b0);
    for (int c = 0; c < 8; c++) begin
      check("R6 irq low", irqN, 1'b0);
      @(negedge clk);
    end
    check("R6 irq ends", irqN, 1'b1);

    // R1 / R2 vector walk over field codes
    for (int v = 0; v < 8; v++) begin
      fieldSel = SEL_VEC[v][18:16];
      #1;
      check((v < 5) ? "R1 field" : "R2 unused code", lowWord(), SEL_VEC[v][15:0]);
    end
    fieldSel = 3'd0;

    // R3 fill to seven, then overflow
    for (int k = 1; k < 7; k++) offerSet(k, 1'b0);
    check("R3 no overflow at seven", ovfl, 1'b0);
    offerSet(7, 1'b0);
    check("R3 overflow set", ovfl, 1'b1);

    // R4 drain in order, R3 dropped set absent
    for (int k = 0; k < 7; k++) begin
      check("R4 order", lowWord(), fieldWord(k, 0));
      popOne();
    end
    check("R5 empty reads zero", lowWord(), 16'h0000);
    check("R3 overflow sticky", ovfl, 1'b1);

    // R5 pop on empty ignored
    popOne();
    offerSet(9, 1'b0);
    check("R5 set after empty pop", lowWord(), fieldWord(9, 0));
    check("R6 irq refires", irqN, 1'b0);
    fieldSel = 3'd4;
    #1;
    check("R1 freq field", lowWord(), fieldWord(9, 4));
    fieldSel = 3'd0;

    // R9 full store with simultaneous push and pop
    for (int k = 10; k < 16; k++) offerSet(k, 1'b0);
    offerSet(20, 1'b1);
    check("R9 head after pop", lowWord(), fieldWord(10, 0));
    for (int k = 10; k < 16; k++) begin
      check("R9 order", lowWord(), fieldWord(k, 0));
      popOne();
    end
    check("R9 new set kept", lowWord(), fieldWord(20, 0));

    // R8 lane enables
    oeALoN = 1'b1;
    #1;
    check("R8 A low off", busA[7:0], 8'h00);
    check("R8 B low on", busB[7:0], 8'h10);
    oeALoN = 1'b0;
    popOne();

    // R7 direct path
    dirA = 16'hABCD; dirB = 16'h1234; dirValid = 1'b1;
    @(negedge clk);
    dirValid = 1'b0; dirA = '0; dirB = '0;
    check("R7 ready strobe", dataRdyN, 1'b0);
    check("R7 high bytes", {busA[15:8], busB[15:8]}, 16'hAB12);
    @(negedge clk);
    check("R7 strobe one cycle", dataRdyN, 1'b1);
    check("R7 high bytes held", {busA[15:8], busB[15:8]}, 16'hAB12);
    oeBHiN = 1'b1;
    #1;
    check("R8 B high off", {busA[15:8], busB[15:8]}, 16'hAB00);
    oeBHiN = 1'b0;

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule